// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block takes a TLB entry pair that an earlier search stage has already matched and turns it into a translation result. Each entry holds two halves, one for an even page and one for an odd page. The page size comes from the entry itself when the entry sits in the fully associative part of the TLB. For the set-associative part it comes from one page-size value shared by all entries. The block uses the virtual address bit at the page-size position to pick the half. It then runs a fixed, ordered series of access-rights checks against the access kind and the current privilege level.

The first failing check decides a 3-bit result code. When every check passes, the block also builds the physical address and the read, write and execute permission bits. A 32-bit mode input turns off the no-execute, no-read and restricted-privilege fields. A low hit input passes a no-match code straight through. The result is registered and appears one clock after the request.

Top module: `tlbe_perm_check`

## Requirements
- R1: One clock edge after an edge with `req_valid` high, `res_valid` is high and the result outputs carry that request's result. After an edge with `req_valid` low, `res_valid` is low and `res_code`, `pa` and the permission bits keep their previous values.
- R2: A request with `hit` low gives `res_code` NOMATCH (1), and no entry check is made. Code values: MATCH=0, NOMATCH=1, INVALID=2, XI=3, RI=4, PE=5, DIRTY=6.
- R3: The page size PS is `entry_ps` when `in_mtlb` is 1 and `global_ps` when `in_mtlb` is 0. It is then clamped into the range 12..47.
- R4: `vaddr` bit PS selects the half: 1 selects `half_odd` and 0 selects `half_even`. Each half has this layout: bit 0 valid, bit 1 dirty, bits 3:2 PLV, bit 4 NX, bit 5 NR, bit 6 RPLV, bits 42:7 PPN.
- R5: Checks run in priority order, and the first failure sets the code: valid=0 gives INVALID, then fetch with NX gives XI, then load with NR gives RI, then a privilege fault gives PE, then store with dirty=0 gives DIRTY. If no check fails, the code is MATCH. Encoding of `acc_type`: 0 fetch, 1 load, 2 store.
- R6: With RPLV=0, a privilege fault occurs when `cur_plv` is greater than the entry's PLV. With RPLV=1, a fault occurs whenever `cur_plv` differs from PLV.
- R7: When `wide_mode` is 0, NX, NR and RPLV are treated as zero.
- R8: The PPN bits that cover address bits 12 up to PS-1 are ignored when the physical address is built.
- R9: On MATCH, `pa` takes bits below PS from `vaddr` and bits PS and above from PPN shifted left by 12.
- R10: On MATCH, `perm_r` is 1, `perm_w` equals the dirty bit, and `perm_x` is the inverse of the effective NX.
- R11: For any result code other than MATCH, `pa` and all permission bits are zero.
- R12: While reset is asserted, `res_valid` is 0, `res_code` is NOMATCH, and `pa` and the permission bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| hit | input | 1 | Search stage found a matching entry |
| in_mtlb | input | 1 | Entry lies in the fully associative region |
| entry_ps | input | 6 | Page size stored in the entry |
| global_ps | input | 6 | Shared page size for the set-associative region |
| vaddr | input | 48 | Virtual address |
| acc_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cur_plv | input | 2 | Current privilege level |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| half_even | input | 43 | Even-page half of the entry |
| half_odd | input | 43 | Odd-page half of the entry |
| res_valid | output | 1 | Result valid |
| res_code | output | 3 | Result code |
| pa | output | 48 | Physical address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
Every result (code, address and permission bits) is due exactly one rising edge after the edge that samples the request. No output changes combinationally. The bench drives each request on a falling edge and reads the outputs on the next falling edge, half a cycle after the registering edge. The hold check drops `req_valid` in the same way and samples one falling edge later. It confirms that `res_valid` has fallen while the code and the address still carry the last result.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;

    typedef enum logic [2:0] {
        RC_MATCH   = 3'd0,
        RC_NOMATCH = 3'd1,
        RC_INVALID = 3'd2,
        RC_XI      = 3'd3,
        RC_RI      = 3'd4,
        RC_PE      = 3'd5,
        RC_DIRTY   = 3'd6
    } res_code_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // attribute bits sit below the page number in each half
    localparam int unsigned ATTR_W   = 7;
    localparam int unsigned PAGE_OFS = 12;

    typedef struct packed {
        logic       rplv;
        logic       nr;
        logic       nx;
        logic [1:0] plv;
        logic       dirty;
        logic       valid;
    } attr_t;

endpackage

// File: rtl/tlbe_half_sel.sv
module tlbe_half_sel #(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned PS_W   = 6,
    parameter int unsigned PS_MIN = 12,
    parameter int unsigned PS_MAX = 47,
    parameter int unsigned HALF_W = 43
) (
    input  logic              in_mtlb,
    input  logic [PS_W-1:0]   entry_ps,
    input  logic [PS_W-1:0]   global_ps,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [HALF_W-1:0] half_even,
    input  logic [HALF_W-1:0] half_odd,
    output logic [PS_W-1:0]   ps_eff,
    output logic [HALF_W-1:0] half_pick
);
    logic [PS_W-1:0] ps_raw;
    logic [VA_W-1:0] va_shift;

    always_comb begin
        ps_raw = in_mtlb ? entry_ps : global_ps;
        if (ps_raw < PS_W'(PS_MIN)) begin
            ps_eff = PS_W'(PS_MIN);
        end else if (ps_raw > PS_W'(PS_MAX)) begin
            ps_eff = PS_W'(PS_MAX);
        end else begin
            ps_eff = ps_raw;
        end
        va_shift  = vaddr >> ps_eff;
        half_pick = va_shift[0] ? half_odd : half_even;
    end
endmodule

// File: rtl/tlbe_rights.sv
module tlbe_rights
    import tlbe_pkg::*;
(
    input  attr_t       attr,
    input  logic        wide_mode,
    input  logic [1:0]  acc_type,
    input  logic [1:0]  cur_plv,
    output res_code_e   code,
    output logic        perm_r,
    output logic        perm_w,
    output logic        perm_x
);
    logic eff_nx;
    logic eff_nr;
    logic eff_rplv;
    logic plv_fault;

    always_comb begin
        eff_nx   = wide_mode & attr.nx;
        eff_nr   = wide_mode & attr.nr;
        eff_rplv = wide_mode & attr.rplv;
        plv_fault = eff_rplv ? (cur_plv != attr.plv) : (cur_plv > attr.plv);

        if (!attr.valid) begin
            code = RC_INVALID;
        end else if ((acc_type == ACC_FETCH) && eff_nx) begin
            code = RC_XI;
        end else if ((acc_type == ACC_LOAD) && eff_nr) begin
            code = RC_RI;
        end else if (plv_fault) begin
            code = RC_PE;
        end else if ((acc_type == ACC_STORE) && !attr.dirty) begin
            code = RC_DIRTY;
        end else begin
            code = RC_MATCH;
        end

        perm_r = 1'b1;
        perm_w = attr.dirty;
        perm_x = !eff_nx;
    end
endmodule

// File: rtl/tlbe_pa_build.sv
module tlbe_pa_build
    import tlbe_pkg::*;
#(
    parameter int unsigned VA_W  = 48,
    parameter int unsigned PA_W  = 48,
    parameter int unsigned PS_W  = 6,
    localparam int unsigned PPN_W = PA_W - PAGE_OFS
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] ppn,
    input  logic [PS_W-1:0]  ps_eff,
    output logic [PA_W-1:0]  pa
);
    // each bit at or above the base page picks offset or frame by PS
    for (genvar i = 0; i < PA_W; i++) begin : g_bit
        if (i < PAGE_OFS) begin : g_low
            assign pa[i] = vaddr[i];
        end else if (i < VA_W) begin : g_mid
            assign pa[i] = (PS_W'(i) < ps_eff) ? vaddr[i] : ppn[i-PAGE_OFS];
        end else begin : g_top
            assign pa[i] = ppn[i-PAGE_OFS];
        end
    end
endmodule

// File: rtl/tlbe_perm_check.sv
module tlbe_perm_check
    import tlbe_pkg::*;
#(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned PA_W   = 48,
    parameter int unsigned PS_W   = 6,
    parameter int unsigned PS_MIN = 12,
    parameter int unsigned PS_MAX = 47
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           hit,
    input  logic                           in_mtlb,
    input  logic [PS_W-1:0]                entry_ps,
    input  logic [PS_W-1:0]                global_ps,
    input  logic [VA_W-1:0]                vaddr,
    input  logic [1:0]                     acc_type,
    input  logic [1:0]                     cur_plv,
    input  logic                           wide_mode,
    input  logic [ATTR_W+PA_W-PAGE_OFS-1:0] half_even,
    input  logic [ATTR_W+PA_W-PAGE_OFS-1:0] half_odd,
    output logic                           res_valid,
    output logic [2:0]                     res_code,
    output logic [PA_W-1:0]                pa,
    output logic                           perm_r,
    output logic                           perm_w,
    output logic                           perm_x
);
    localparam int unsigned PPN_W  = PA_W - PAGE_OFS;
    localparam int unsigned HALF_W = ATTR_W + PPN_W;

    typedef struct packed {
        logic            valid;
        logic [2:0]      code;
        logic [PA_W-1:0] pa;
        logic            r;
        logic            w;
        logic            x;
    } out_t;

    logic [PS_W-1:0]   ps_eff;
    logic [HALF_W-1:0] half_pick;
    attr_t             attr;
    logic [PPN_W-1:0]  ppn;
    res_code_e         chk_code;
    logic              chk_r, chk_w, chk_x;
    logic [PA_W-1:0]   pa_raw;
    out_t              out_d, out_q;

    tlbe_half_sel #(
        .VA_W(VA_W), .PS_W(PS_W), .PS_MIN(PS_MIN), .PS_MAX(PS_MAX), .HALF_W(HALF_W)
    ) u_sel (
        .in_mtlb  (in_mtlb),
        .entry_ps (entry_ps),
        .global_ps(global_ps),
        .vaddr    (vaddr),
        .half_even(half_even),
        .half_odd (half_odd),
        .ps_eff   (ps_eff),
        .half_pick(half_pick)
    );

    assign attr = attr_t'(half_pick[ATTR_W-1:0]);
    assign ppn  = half_pick[HALF_W-1:ATTR_W];

    tlbe_rights u_rights (
        .attr     (attr),
        .wide_mode(wide_mode),
        .acc_type (acc_type),
        .cur_plv  (cur_plv),
        .code     (chk_code),
        .perm_r   (chk_r),
        .perm_w   (chk_w),
        .perm_x   (chk_x)
    );

    tlbe_pa_build #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_pa (
        .vaddr (vaddr),
        .ppn   (ppn),
        .ps_eff(ps_eff),
        .pa    (pa_raw)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_valid;
        if (req_valid) begin
            out_d.pa = '0;
            out_d.r  = 1'b0;
            out_d.w  = 1'b0;
            out_d.x  = 1'b0;
            if (!hit) begin
                out_d.code = RC_NOMATCH;
            end else begin
                out_d.code = chk_code;
                if (chk_code == RC_MATCH) begin
                    out_d.pa = pa_raw;
                    out_d.r  = chk_r;
                    out_d.w  = chk_w;
                    out_d.x  = chk_x;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, code: RC_NOMATCH, pa: '0, r: 1'b0, w: 1'b0, x: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign res_valid = out_q.valid;
    assign res_code  = out_q.code;
    assign pa        = out_q.pa;
    assign perm_r    = out_q.r;
    assign perm_w    = out_q.w;
    assign perm_x    = out_q.x;
endmodule

// File: rtl/tlbe_perm_check_sva.sv
module tlbe_perm_check_sva
    import tlbe_pkg::*;
#(
    parameter int unsigned PA_W = 48
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            hit,
    input logic [1:0]                      acc_type,
    input logic                            wide_mode,
    input logic [ATTR_W+PA_W-PAGE_OFS-1:0] half_even,
    input logic [ATTR_W+PA_W-PAGE_OFS-1:0] half_odd,
    input logic                            res_valid,
    input logic [2:0]                      res_code,
    input logic [PA_W-1:0]                 pa,
    input logic                            perm_r,
    input logic                            perm_w,
    input logic                            perm_x
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_code) && $stable(pa)));

    a_r2_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (res_code == RC_NOMATCH));

    a_r5_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !half_even[0] && !half_odd[0]) |=> (res_code == RC_INVALID));

    a_r5_xi_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && acc_type != ACC_FETCH) |=> (res_code != RC_XI));

    a_r7_narrow_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !wide_mode) |=> (res_code != RC_XI && res_code != RC_RI));

    a_r10_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == RC_MATCH) |-> perm_r);

    a_r11_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != RC_MATCH) |-> (pa == '0 && !perm_r && !perm_w && !perm_x));
endmodule

bind tlbe_perm_check tlbe_perm_check_sva #(.PA_W(PA_W)) u_sva (.*);

// File: tb/tlbe_perm_check_test.sv
module tlbe_perm_check_test;
    import tlbe_pkg::*;

    localparam int unsigned WD_CYCLES = 20000;

    function automatic logic [42:0] mk(input logic v, input logic d, input logic [1:0] lvl,
                                       input logic nx, input logic nr, input logic rp,
                                       input logic [35:0] ppn);
        return {ppn, rp, nr, nx, lvl, d, v};
    endfunction

    typedef struct packed {
        logic [3:0]  tag;
        logic        mtlb;
        logic [5:0]  eps;
        logic [5:0]  gps;
        logic [47:0] va;
        logic [1:0]  acc;
        logic [1:0]  lvl;
        logic        wide;
        logic        hit;
        logic [42:0] h0;
        logic [42:0] h1;
        logic [2:0]  code;
        logic [47:0] pa;
        logic [2:0]  rwx;
    } vec_t;

    localparam logic [42:0] DEC = 43'({36'hFFFFF, 7'b0000011});

    localparam vec_t VECS [16] = '{
        // R9 4 KiB even page
        '{4'd9, 1'b1, 6'd12, 6'd12, 48'h0ABC, 2'd1, 2'd0, 1'b1, 1'b1,
          43'({36'h12345, 7'b0000011}), DEC, 3'd0, 48'h12345ABC, 3'b111},
        // R4 4 KiB odd page
        '{4'd4, 1'b1, 6'd12, 6'd12, 48'h1ABC, 2'd1, 2'd3, 1'b1, 1'b1,
          DEC, 43'({36'h777, 7'b0011101}), 3'd0, 48'h777ABC, 3'b100},
        // R8 16 KiB from shared size, software bits dropped
        '{4'd8, 1'b0, 6'd12, 6'd14, 48'h2345, 2'd2, 2'd0, 1'b1, 1'b1,
          43'({36'h12347, 7'b0000011}), DEC, 3'd0, 48'h12346345, 3'b111},
        // R3 2 MiB from entry size
        '{4'd3, 1'b1, 6'd21, 6'd12, 48'h301234, 2'd0, 2'd1, 1'b1, 1'b1,
          DEC, 43'({36'hA5F, 7'b0001001}), 3'd0, 48'hB01234, 3'b101},
        // R5 invalid beats everything
        '{4'd5, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd0, 2'd3, 1'b1, 1'b1,
          43'({36'h12345, 7'b0110000}), DEC, 3'd2, 48'h0, 3'b000},
        // R5 XI beats PE
        '{4'd5, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd0, 2'd3, 1'b1, 1'b1,
          43'({36'h12345, 7'b0110001}), DEC, 3'd3, 48'h0, 3'b000},
        // R5 RI beats PE
        '{4'd5, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd1, 2'd3, 1'b1, 1'b1,
          43'({36'h12345, 7'b0110001}), DEC, 3'd4, 48'h0, 3'b000},
        // R6 rule 0: higher level faults
        '{4'd6, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd1, 2'd2, 1'b1, 1'b1,
          43'({36'h12345, 7'b0000101}), DEC, 3'd5, 48'h0, 3'b000},
        // R6 rule 1: lower level also faults
        '{4'd6, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd1, 2'd0, 1'b1, 1'b1,
          43'({36'h12345, 7'b1000111}), DEC, 3'd5, 48'h0, 3'b000},
        // R6 rule 1: equal level passes
        '{4'd6, 1'b1, 6'd12, 6'd12, 48'h0F00, 2'd2, 2'd1, 1'b1, 1'b1,
          43'({36'h12345, 7'b1000111}), DEC, 3'd0, 48'h12345F00, 3'b111},
        // R5 store to clean page
        '{4'd5, 1'b1, 6'd12, 6'd12, 48'h0100, 2'd2, 2'd0, 1'b1, 1'b1,
          43'({36'h12345, 7'b0000001}), DEC, 3'd6, 48'h0, 3'b000},
        // R7 narrow mode ignores NX and RPLV
        '{4'd7, 1'b1, 6'd12, 6'd12, 48'h30008, 2'd0, 2'd1, 1'b0, 1'b1,
          43'({36'h12345, 7'b1111011}), DEC, 3'd0, 48'h12345008, 3'b111},
        // R10 narrow mode ignores NR, execute granted
        '{4'd10, 1'b1, 6'd12, 6'd12, 48'h0004, 2'd1, 2'd0, 1'b0, 1'b1,
          43'({36'h12345, 7'b0110001}), DEC, 3'd0, 48'h12345004, 3'b101},
        // R2 no hit
        '{4'd2, 1'b1, 6'd12, 6'd12, 48'h0ABC, 2'd1, 2'd0, 1'b1, 1'b0,
          43'({36'h12345, 7'b0000011}), DEC, 3'd1, 48'h0, 3'b000},
        // R3 small size clamped up to 12
        '{4'd3, 1'b1, 6'd5, 6'd12, 48'h1FDF, 2'd1, 2'd0, 1'b1, 1'b1,
          DEC, 43'({36'h42, 7'b0000011}), 3'd0, 48'h42FDF, 3'b111},
        // R3 large size clamped down to 47
        '{4'd3, 1'b1, 6'd63, 6'd12, 48'h8000_0000_1234, 2'd1, 2'd0, 1'b1, 1'b1,
          DEC, 43'({36'h8_0000_0000, 7'b0000011}), 3'd0, 48'h8000_0000_1234, 3'b111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        hit = 1'b0;
    logic        in_mtlb = 1'b0;
    logic [5:0]  entry_ps = 6'd12;
    logic [5:0]  global_ps = 6'd12;
    logic [47:0] vaddr = '0;
    logic [1:0]  acc_type = 2'd0;
    logic [1:0]  cur_plv = 2'd0;
    logic        wide_mode = 1'b1;
    logic [42:0] half_even = '0;
    logic [42:0] half_odd = '0;
    logic        res_valid;
    logic [2:0]  res_code;
    logic [47:0] pa;
    logic        perm_r, perm_w, perm_x;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlbe_perm_check uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
        .in_mtlb(in_mtlb), .entry_ps(entry_ps), .global_ps(global_ps),
        .vaddr(vaddr), .acc_type(acc_type), .cur_plv(cur_plv),
        .wide_mode(wide_mode), .half_even(half_even), .half_odd(half_odd),
        .res_valid(res_valid), .res_code(res_code), .pa(pa),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        chk("R12", "res_valid", 64'(res_valid), 64'd0);
        chk("R12", "res_code", 64'(res_code), 64'(RC_NOMATCH));
        chk("R12", "pa/perm", 64'({pa, perm_r, perm_w, perm_x}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            vec_t v;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d row%0d", v.tag, i);
            req_valid = 1'b1;
            hit       = v.hit;
            in_mtlb   = v.mtlb;
            entry_ps  = v.eps;
            global_ps = v.gps;
            vaddr     = v.va;
            acc_type  = v.acc;
            cur_plv   = v.lvl;
            wide_mode = v.wide;
            half_even = v.h0;
            half_odd  = v.h1;
            @(negedge clk);
            chk(tg, "res_valid", 64'(res_valid), 64'd1);
            chk(tg, "res_code", 64'(res_code), 64'(v.code));
            chk(tg, "pa", 64'(pa), 64'(v.pa));
            chk(tg, "rwx", 64'({perm_r, perm_w, perm_x}), 64'(v.rwx));
        end

        // R1 idle cycle holds last result
        req_valid = 1'b0;
        vaddr     = 48'h0;
        hit       = 1'b0;
        @(negedge clk);
        chk("R1", "res_valid idle", 64'(res_valid), 64'd0);
        chk("R1", "code held", 64'(res_code), 64'(RC_MATCH));
        chk("R1", "pa held", 64'(pa), 64'h8000_0000_1234);

        // R11 fault after match clears address and permissions
        req_valid = 1'b1;
        hit       = 1'b1;
        in_mtlb   = 1'b1;
        entry_ps  = 6'd12;
        vaddr     = 48'h0100;
        acc_type  = 2'd2;
        cur_plv   = 2'd0;
        wide_mode = 1'b1;
        half_even = mk(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 36'h12345);
        @(negedge clk);
        chk("R11", "code", 64'(res_code), 64'(RC_DIRTY));
        chk("R11", "pa/perm", 64'({pa, perm_r, perm_w, perm_x}), 64'd0);
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule